// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Operand Bypass Control

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register numbers of the instruction in decode and of the instruction in execute. It also looks at the destination register, write flag and load flag of the instructions in execute, memory and writeback. From these it decides two things: whether the front of the pipe must freeze, and where each execute operand must come from.

A mode input picks one of two policies. With bypassing enabled, results are steered from the memory-stage or writeback-stage pipeline register straight into execute. The only stall left is the single cycle a loaded value needs before it exists. With bypassing disabled, every operand comes from the register file. A dependent instruction then waits in decode until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second, so a producer in writeback and a consumer in decode do not conflict.

The decisions are combinational, so the datapath can apply them in the same cycle. The clock and reset serve only the built-in property checks.

Top module: `hzd_ctrl`

## Requirements
- R1: Register number 0 never takes part in a hazard: a destination of 0 causes no stall and no bypass, and a source of 0 is never stalled or bypassed.
- R2: With bypassing disabled, a decode source that equals the destination of a writing instruction in execute or in memory raises the stall. A consumer issued directly behind its producer therefore sees exactly two stall cycles.
- R3: A decode source that equals only the destination of a writing instruction in writeback causes no stall in either mode.
- R4: With bypassing disabled, both operand selects are 00 (register file).
- R5: With bypassing enabled, the stall is raised only when execute holds a writing load whose destination equals a decode source. A writing non-load in execute causes no stall.
- R6: With bypassing enabled, an execute source that equals the destination of a writing non-load in memory gets select 01 (memory-stage ALU result).
- R7: With bypassing enabled, an execute source that equals the destination of a writing instruction in writeback, and is not matched in memory, gets select 10 (writeback-stage value).
- R8: When both memory and writeback match an execute source, the memory stage (younger result) wins with select 01.
- R9: An instruction whose write flag is low is never a producer: it causes neither a stall nor a bypass.
- R10: Output wb_take_mem is 1 exactly when the writeback instruction is a writing load, so a select of 10 means the memory read value; otherwise it means the ALU result.
- R11: A load in memory whose destination matches an execute source yields select 00, never its ALU result.
- R12: pc_hold, ifid_hold and idex_bubble are always asserted together. The bubble carries a cleared write flag into execute, while the PC and the fetch/decode register keep their values.
- R13: The select code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the property checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| fwd_en | input | 1 | 1 = bypassing policy, 0 = stall-only policy |
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| exe_src_a | input | REG_W | First source register of the execute instruction |
| exe_src_b | input | REG_W | Second source register of the execute instruction |
| exe_dst | input | REG_W | Destination of the execute instruction |
| exe_wr | input | 1 | Execute instruction writes a register |
| exe_ld | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_W | Destination of the writeback instruction |
| wb_wr | input | 1 | Writeback instruction writes a register |
| wb_ld | input | 1 | Writeback instruction is a load |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-write bubble into the decode/execute register |
| opsel_a | output | 2 | Source select of execute operand A (00 file, 01 memory stage, 10 writeback stage) |
| opsel_b | output | 2 | Source select of execute operand B |
| wb_take_mem | output | 1 | Writeback-stage value is the memory read data (else ALU result) |

## Verification
If a register comparison went wrong, the fault shows at the ports in the same cycle. A missed match leaves the hold outputs low, or the select at 00, while a producer is still in flight. A spurious match raises a stall or a non-zero select, for example on register 0 or on a store. The bench walks a dependent pair through the stall-only pipe cycle by cycle, so a wrong stall window shows up as a third stall cycle or a missing second one. Priority faults show up only when both later stages carry the same destination, so the bench sets up that case directly.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    OPSEL_FILE = 2'b00,
    OPSEL_MEMSTG = 2'b01,
    OPSEL_WBSTG = 2'b10
  } opsel_e;
endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wr,
  output logic             hit
);
  // a producer counts only if it writes and does not target the zero register
  always_comb begin
    hit = wr && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/hzd_opsel.sv
module hzd_opsel
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             fwd_en,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_ld,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic [1:0]       sel
);
  logic    hit_mem;
  logic    hit_wb;
  opsel_e  sel_e;

  hzd_match #(.REG_W(REG_W)) u_mem (.src(src), .dst(mem_dst), .wr(mem_wr), .hit(hit_mem));
  hzd_match #(.REG_W(REG_W)) u_wb  (.src(src), .dst(wb_dst),  .wr(wb_wr),  .hit(hit_wb));

  // younger memory-stage result wins; a load there has no usable data yet
  always_comb begin
    sel_e = OPSEL_FILE;
    if (fwd_en) begin
      if (hit_mem) begin
        sel_e = mem_ld ? OPSEL_FILE : OPSEL_MEMSTG;
      end else if (hit_wb) begin
        sel_e = OPSEL_WBSTG;
      end
    end
  end

  assign sel = sel_e;
endmodule

// File: rtl/hzd_stall.sv
module hzd_stall #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                           fwd_en,
  input  logic [NUM_SRC-1:0][REG_W-1:0]  srcs,
  input  logic [REG_W-1:0]               exe_dst,
  input  logic                           exe_wr,
  input  logic                           exe_ld,
  input  logic [REG_W-1:0]               mem_dst,
  input  logic                           mem_wr,
  output logic                           stall
);
  logic [NUM_SRC-1:0] hit_exe;
  logic [NUM_SRC-1:0] hit_mem;
  logic [NUM_SRC-1:0] need;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    hzd_match #(.REG_W(REG_W)) u_exe (.src(srcs[i]), .dst(exe_dst), .wr(exe_wr), .hit(hit_exe[i]));
    hzd_match #(.REG_W(REG_W)) u_mem (.src(srcs[i]), .dst(mem_dst), .wr(mem_wr), .hit(hit_mem[i]));
    // bypass mode: only a load one stage ahead must wait
    // stall-only mode: wait until the producer reaches writeback
    assign need[i] = fwd_en ? (hit_exe[i] && exe_ld) : (hit_exe[i] || hit_mem[i]);
  end

  assign stall = |need;
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_en,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] exe_src_a,
  input  logic [REG_W-1:0] exe_src_b,
  input  logic [REG_W-1:0] exe_dst,
  input  logic             exe_wr,
  input  logic             exe_ld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_ld,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  input  logic             wb_ld,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic [1:0]       opsel_a,
  output logic [1:0]       opsel_b,
  output logic             wb_take_mem
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] dec_srcs;
  logic [NUM_SRC-1:0][REG_W-1:0] exe_srcs;
  logic [NUM_SRC-1:0][1:0]       sels;
  logic                          stall;

  assign dec_srcs = {dec_src_b, dec_src_a};
  assign exe_srcs = {exe_src_b, exe_src_a};

  hzd_stall #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_stall (
    .fwd_en (fwd_en),
    .srcs   (dec_srcs),
    .exe_dst(exe_dst),
    .exe_wr (exe_wr),
    .exe_ld (exe_ld),
    .mem_dst(mem_dst),
    .mem_wr (mem_wr),
    .stall  (stall)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
    hzd_opsel #(.REG_W(REG_W)) u_sel (
      .fwd_en (fwd_en),
      .src    (exe_srcs[i]),
      .mem_dst(mem_dst),
      .mem_wr (mem_wr),
      .mem_ld (mem_ld),
      .wb_dst (wb_dst),
      .wb_wr  (wb_wr),
      .sel    (sels[i])
    );
  end

  // freeze the front and squash into execute as one action
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign opsel_a     = sels[0];
  assign opsel_b     = sels[1];
  assign wb_take_mem = wb_wr && wb_ld;

  // R4: stall-only policy reads everything from the file
  assert_file_only_R4: assert property (@(posedge clk) disable iff (rst)
    !fwd_en |-> (opsel_a == 2'b00 && opsel_b == 2'b00));

  // R13: select code 11 is unused
  assert_no_code3_R13: assert property (@(posedge clk) disable iff (rst)
    opsel_a != 2'b11 && opsel_b != 2'b11);

  // R5: with bypassing, a stall needs a writing load in execute
  assert_fwd_stall_load_R5: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && pc_hold) |-> (exe_ld && exe_wr));

  // R6 / R11: memory-stage select needs a writing non-load producer
  assert_memsel_src_R6: assert property (@(posedge clk) disable iff (rst)
    (opsel_a == 2'b01) |-> (mem_wr && !mem_ld && mem_dst != '0));

  // R1: zero sources never stall
  assert_zero_nostall_R1: assert property (@(posedge clk) disable iff (rst)
    (dec_src_a == '0 && dec_src_b == '0) |-> !pc_hold);

  // R9: with no writer ahead in execute or memory, there is no stall
  assert_no_writer_R9: assert property (@(posedge clk) disable iff (rst)
    (!exe_wr && !mem_wr) |-> !idex_bubble);
endmodule

// File: tb/hzd_ctrl_tb.sv
module hzd_ctrl_tb;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fwd_en;
  logic [RW-1:0] dec_src_a, dec_src_b, exe_src_a, exe_src_b;
  logic [RW-1:0] exe_dst, mem_dst, wb_dst;
  logic exe_wr, exe_ld, mem_wr, mem_ld, wb_wr, wb_ld;
  logic pc_hold, ifid_hold, idex_bubble, wb_take_mem;
  logic [1:0] opsel_a, opsel_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hzd_ctrl #(.REG_W(RW)) u_dut (
    .clk(clk), .rst(rst), .fwd_en(fwd_en),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .exe_src_a(exe_src_a), .exe_src_b(exe_src_b),
    .exe_dst(exe_dst), .exe_wr(exe_wr), .exe_ld(exe_ld),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_ld(mem_ld),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_ld(wb_ld),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .opsel_a(opsel_a), .opsel_b(opsel_b), .wb_take_mem(wb_take_mem)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // holds packed as {pc,ifid,bubble}
  function automatic int holds();
    return {29'd0, pc_hold, ifid_hold, idex_bubble};
  endfunction

  task automatic clear(input logic mode);
    @(negedge clk);
    fwd_en = mode;
    dec_src_a = '0; dec_src_b = '0; exe_src_a = '0; exe_src_b = '0;
    exe_dst = '0; mem_dst = '0; wb_dst = '0;
    exe_wr = 0; exe_ld = 0; mem_wr = 0; mem_ld = 0; wb_wr = 0; wb_ld = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    clear(1'b1);
    settle();
    chk("R12 reset holds", holds(), 0);
    chk("R1 reset opsel_a", opsel_a, 0);
    chk("R1 reset opsel_b", opsel_b, 0);
    chk("R10 reset wb_take_mem", wb_take_mem, 0);
  endtask

  task automatic t_zero_reg();
    for (int m = 0; m < 2; m++) begin
      clear(m[0]);
      exe_dst = 0; exe_wr = 1; exe_ld = 1; mem_dst = 0; mem_wr = 1; wb_dst = 0; wb_wr = 1;
      settle();
      chk("R1 zero dst no stall", holds(), 0);
      chk("R1 zero dst opsel_a", opsel_a, 0);
    end
  endtask

  task automatic t_nofwd_stall();
    clear(1'b0);
    exe_dst = 5'd7; exe_wr = 1; dec_src_b = 5'd7;
    settle();
    chk("R2 exe match stalls", holds(), 7);
    clear(1'b0);
    mem_dst = 5'd9; mem_wr = 1; dec_src_a = 5'd9;
    settle();
    chk("R2 mem match stalls", holds(), 7);
    clear(1'b0);
    wb_dst = 5'd9; wb_wr = 1; dec_src_a = 5'd9;
    settle();
    chk("R3 wb match no stall off", holds(), 0);
  endtask

  task automatic t_nofwd_seq();
    int stalls = 0;
    clear(1'b0);
    // producer to r4 in execute, consumer in decode
    exe_dst = 5'd4; exe_wr = 1; dec_src_a = 5'd4;
    settle(); if (pc_hold) stalls++;
    @(negedge clk); // producer moves to memory, bubble in execute
    mem_dst = 5'd4; mem_wr = 1; exe_dst = 0; exe_wr = 0;
    settle(); if (pc_hold) stalls++;
    @(negedge clk); // producer moves to writeback
    wb_dst = 5'd4; wb_wr = 1; mem_dst = 0; mem_wr = 0;
    settle(); if (pc_hold) stalls++;
    chk("R2 two stall cycles", stalls, 2);
    chk("R3 released in writeback", holds(), 0);
  endtask

  task automatic t_nofwd_sel();
    clear(1'b0);
    exe_src_a = 5'd3; exe_src_b = 5'd6; mem_dst = 5'd3; mem_wr = 1; wb_dst = 5'd6; wb_wr = 1;
    settle();
    chk("R4 off opsel_a", opsel_a, 0);
    chk("R4 off opsel_b", opsel_b, 0);
  endtask

  task automatic t_fwd_stall();
    clear(1'b1);
    exe_dst = 5'd8; exe_wr = 1; dec_src_a = 5'd8;
    settle();
    chk("R5 alu producer no stall", holds(), 0);
    exe_ld = 1;
    settle();
    chk("R5 load-use stall", holds(), 7);
    clear(1'b1);
    mem_dst = 5'd8; mem_wr = 1; mem_ld = 1; dec_src_b = 5'd8;
    settle();
    chk("R5 mem producer no stall", holds(), 0);
    wb_dst = 5'd11; wb_wr = 1; dec_src_a = 5'd11;
    settle();
    chk("R3 wb producer no stall on", holds(), 0);
  endtask

  task automatic t_fwd_sel();
    clear(1'b1);
    exe_src_a = 5'd12; exe_src_b = 5'd13; mem_dst = 5'd13; mem_wr = 1; wb_dst = 5'd12; wb_wr = 1;
    settle();
    chk("R6 mem bypass opsel_b", opsel_b, 1);
    chk("R7 wb bypass opsel_a", opsel_a, 2);
    chk("R10 alu in wb", wb_take_mem, 0);
    wb_ld = 1;
    settle();
    chk("R10 load in wb", wb_take_mem, 1);
    chk("R7 wb load still 10", opsel_a, 2);
  endtask

  task automatic t_prio();
    clear(1'b1);
    exe_src_a = 5'd20; exe_src_b = 5'd20; mem_dst = 5'd20; mem_wr = 1; wb_dst = 5'd20; wb_wr = 1;
    settle();
    chk("R8 younger wins a", opsel_a, 1);
    chk("R8 younger wins b", opsel_b, 1);
  endtask

  task automatic t_noprod();
    clear(1'b1);
    exe_dst = 5'd2; exe_ld = 1; dec_src_a = 5'd2;
    mem_dst = 5'd5; wb_dst = 5'd5; exe_src_a = 5'd5; exe_src_b = 5'd5;
    settle();
    chk("R9 no-write no stall", holds(), 0);
    chk("R9 no-write opsel_a", opsel_a, 0);
    chk("R9 no-write opsel_b", opsel_b, 0);
    fwd_en = 0;
    mem_dst = 5'd2;
    settle();
    chk("R9 no-write no stall off", holds(), 0);
  endtask

  task automatic t_memload();
    clear(1'b1);
    exe_src_b = 5'd17; mem_dst = 5'd17; mem_wr = 1; mem_ld = 1;
    settle();
    chk("R11 load in mem gives 00", opsel_b, 0);
  endtask

  task automatic t_sweep();
    int seen3 = 0;
    int mism = 0;
    clear(1'b1);
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 4; w++) begin
        @(negedge clk);
        exe_src_a = 5'd1; exe_src_b = 5'd2;
        mem_dst = m[1:0]; mem_wr = 1; mem_ld = m[0];
        wb_dst = w[1:0]; wb_wr = 1;
        exe_dst = m[1:0]; exe_wr = 1; exe_ld = w[0]; dec_src_a = 5'd1;
        settle();
        if (opsel_a == 2'b11 || opsel_b == 2'b11) seen3++;
        if (pc_hold != ifid_hold || pc_hold != idex_bubble) mism++;
      end
    end
    chk("R13 no code 11", seen3, 0);
    chk("R12 holds together", mism, 0);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear(1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_reg();
    t_nofwd_stall();
    t_nofwd_seq();
    t_nofwd_sel();
    t_fwd_stall();
    t_fwd_sel();
    t_prio();
    t_noprod();
    t_memload();
    t_sweep();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule